// File: doc/BRIEF.md
# Dual-Read Register File with Per-Port Read Timing

This block is a small storage array of 32 words, 4 bits each. It has one write port and two read ports, A and B, and a single clock drives all three. Writes are synchronous: the addressed word takes the write data on the rising edge while the write enable is high.

Each read port can be set to one of two timing modes by its own bit in a two-bit mode input. In combinational mode the port's output follows the addressed word with no clock involved. In clocked mode the addressed word is captured into an output register on the rising edge. A clocked read of the address being written in the same cycle returns the word as it was before that write.

The mode bits are meant to be static or to change only rarely. The array itself is never cleared. The synchronous active-high reset clears only the two read output registers.

Top module: `dualread_regfile`

## Requirements
- R1: The array holds 32 words of 4 bits, addressed by a 5-bit address. On a rising clock edge with `wr_en` = 1, the word at `wr_addr` takes `wr_data`, and a later read of that address returns it.
- R2: On a rising edge with `wr_en` = 0, no word changes, whatever `wr_addr` and `wr_data` hold.
- R3: A port whose mode bit is 0 (combinational) drives the word at its current address, and it follows an address change with no clock edge.
- R4: In combinational mode, reading the address being written shows the old word until the edge that commits the write, and the new word after that edge. No value is passed through from the write data.
- R5: A port whose mode bit is 1 (clocked) shows the word its address selected at the last rising edge, and it keeps that value when its address changes between edges.
- R6: A clocked read of the address written in the same cycle returns the word held before that write. The new word appears on the next clocked read.
- R7: `rd_mode` bit 0 sets the mode of port A and bit 1 sets the mode of port B. The two ports are set independently, so any mix of modes works.
- R8: A rising edge with `rst` = 1 clears the clocked output registers to 0. Array contents are kept and stay readable.
- R9: The two read ports work at the same time on different addresses without affecting each other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared clock, rising edge |
| rst | input | 1 | Synchronous active-high reset of the read output registers |
| rd_mode | input | 2 | Read timing: bit 0 for port A, bit 1 for port B; 1 = clocked, 0 = combinational |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 5 | Write address |
| wr_data | input | 4 | Write data |
| rd_a_addr | input | 5 | Port A read address |
| rd_a_data | output | 4 | Port A read data |
| rd_b_addr | input | 5 | Port B read address |
| rd_b_data | output | 4 | Port B read data |

## Verification
The bench targets the cycle in which a read and a write hit the same address. A combinational port that passed write data through before the edge would show the new word too early. A clocked port that sampled after the write, or that read the array through a bypass, would return the new word where the old one is required. Changing the address between edges, in each mixed mode setting, catches a clocked port that leaks combinational data and a pair of mode bits wired to the wrong ports. Resetting after the array has been filled catches a reset that wipes the array or fails to clear the clocked outputs.

// File: rtl/rf_pkg.sv
package rf_pkg;
  typedef enum logic {
    RD_COMB    = 1'b0,
    RD_CLOCKED = 1'b1
  } rd_mode_e;
endpackage

// File: rtl/rf_store.sv
module rf_store #(
  parameter int ENTRIES = 32,
  parameter int DATA_W  = 4,
  parameter int NUM_RD  = 2,
  parameter int ADDR_W  = $clog2(ENTRIES)
) (
  input  logic                           clk,
  input  logic                           we,
  input  logic [ADDR_W-1:0]              waddr,
  input  logic [DATA_W-1:0]              wdata,
  input  logic [NUM_RD-1:0][ADDR_W-1:0]  raddr,
  output logic [NUM_RD-1:0][DATA_W-1:0]  rword
);
  // Distributed-style array: one synchronous write, unregistered reads.
  logic [DATA_W-1:0] mem [ENTRIES];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  for (genvar g = 0; g < NUM_RD; g++) begin : g_rd
    assign rword[g] = mem[raddr[g]];
  end
endmodule

// File: rtl/rf_read_port.sv
module rf_read_port
  import rf_pkg::*;
#(
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  rd_mode_e          mode,
  input  logic [DATA_W-1:0] word_in,
  output logic [DATA_W-1:0] dout
);
  logic [DATA_W-1:0] cap_q;
  logic              past_ok;

  // Capture the array word as sampled before this edge's write lands.
  always_ff @(posedge clk) begin
    if (rst) cap_q <= '0;
    else     cap_q <= word_in;
  end

  always_ff @(posedge clk) begin
    if (rst) past_ok <= 1'b0;
    else     past_ok <= 1'b1;
  end

  assign dout = (mode == RD_CLOCKED) ? cap_q : word_in;

  // R5: clocked output equals the word selected at the previous edge
  p_clocked_capture_r5: assert property (@(posedge clk) disable iff (rst)
    (past_ok && mode == RD_CLOCKED) |-> dout == $past(word_in));

  // R8: after reset release a clocked port shows zero
  p_reset_clear_r8: assert property (@(posedge clk) disable iff (rst)
    ($fell(rst) && mode == RD_CLOCKED) |-> dout == '0);
endmodule

// File: rtl/dualread_regfile.sv
module dualread_regfile
  import rf_pkg::*;
#(
  parameter int ENTRIES = 32,
  parameter int DATA_W  = 4,
  parameter int ADDR_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        rd_mode,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_a_addr,
  output logic [DATA_W-1:0] rd_a_data,
  input  logic [ADDR_W-1:0] rd_b_addr,
  output logic [DATA_W-1:0] rd_b_data
);
  localparam int NUM_RD = 2;

  logic [NUM_RD-1:0][ADDR_W-1:0] raddr;
  logic [NUM_RD-1:0][DATA_W-1:0] rword;
  logic [NUM_RD-1:0][DATA_W-1:0] rdout;
  logic                          past_ok;

  assign raddr = {rd_b_addr, rd_a_addr};

  rf_store #(
    .ENTRIES(ENTRIES), .DATA_W(DATA_W), .NUM_RD(NUM_RD), .ADDR_W(ADDR_W)
  ) u_store (
    .clk(clk), .we(wr_en), .waddr(wr_addr), .wdata(wr_data),
    .raddr(raddr), .rword(rword)
  );

  // Bit g of rd_mode picks the timing of read port g (0 = A, 1 = B).
  for (genvar g = 0; g < NUM_RD; g++) begin : g_port
    rf_read_port #(.DATA_W(DATA_W)) u_port (
      .clk(clk), .rst(rst), .mode(rd_mode_e'(rd_mode[g])),
      .word_in(rword[g]), .dout(rdout[g])
    );
  end

  assign rd_a_data = rdout[0];
  assign rd_b_data = rdout[1];

  always_ff @(posedge clk) begin
    if (rst) past_ok <= 1'b0;
    else     past_ok <= 1'b1;
  end

  // R1: a committed write is visible on a combinational port reading it
  p_write_visible_a_r1: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(wr_en) && !rd_mode[0] && rd_a_addr == $past(wr_addr))
    |-> rd_a_data == $past(wr_data));

  p_write_visible_b_r1: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(wr_en) && !rd_mode[1] && rd_b_addr == $past(wr_addr))
    |-> rd_b_data == $past(wr_data));

  // R6: a clocked read colliding with a write returns the old word
  p_collide_old_r6: assert property (@(posedge clk) disable iff (rst)
    (past_ok && rd_mode[0] && $past(wr_en) && $past(rd_a_addr) == $past(wr_addr))
    |-> rd_a_data == $past(rword[0]));
endmodule

// File: tb/test_dualread_regfile.sv
module test_dualread_regfile;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] rd_mode = 2'b11;
  logic       wr_en = 1'b0;
  logic [4:0] wr_addr = '0;
  logic [3:0] wr_data = '0;
  logic [4:0] rd_a_addr = '0;
  logic [3:0] rd_a_data;
  logic [4:0] rd_b_addr = '0;
  logic [3:0] rd_b_data;

  logic [3:0] model [32];
  int n_run = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  dualread_regfile i_dualread_regfile (
    .clk(clk), .rst(rst), .rd_mode(rd_mode), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_a_addr(rd_a_addr), .rd_a_data(rd_a_data),
    .rd_b_addr(rd_b_addr), .rd_b_data(rd_b_data)
  );

  task automatic check(input string req, input logic [3:0] got, input logic [3:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [3:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    model[a] = d;
    wr_en = 1'b0;
  endtask

  task automatic t_reset;
    rd_mode = 2'b11; rst = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    check("R8 reset A", rd_a_data, 4'h0);
    check("R8 reset B", rd_b_data, 4'h0);
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic t_fill;
    rd_mode = 2'b00;
    for (int i = 0; i < 32; i++) wr(5'(i), 4'((i * 7 + 3) & 15));
    for (int i = 0; i < 32; i++) begin
      @(negedge clk);
      rd_a_addr = 5'(i); rd_b_addr = 5'(31 - i);
      #1;
      check("R1/R3 port A", rd_a_data, model[i]);
      check("R9 port B", rd_b_data, model[31 - i]);
    end
  endtask

  task automatic t_no_write;
    logic [3:0] old;
    rd_mode = 2'b00;
    old = model[5];
    @(negedge clk);
    wr_en = 1'b0; wr_addr = 5'd5; wr_data = ~old; rd_a_addr = 5'd5;
    @(posedge clk); #1;
    check("R2 disabled write", rd_a_data, old);
  endtask

  task automatic t_async_no_bypass;
    logic [3:0] old;
    logic [3:0] nw;
    rd_mode = 2'b00;
    old = model[9]; nw = ~old;
    @(negedge clk);
    rd_a_addr = 5'd9; wr_en = 1'b1; wr_addr = 5'd9; wr_data = nw;
    #1;
    check("R4 before edge", rd_a_data, old);
    @(posedge clk); #1;
    wr_en = 1'b0; model[9] = nw;
    check("R4 after edge", rd_a_data, nw);
  endtask

  task automatic t_sync_hold;
    @(negedge clk);
    rd_mode = 2'b11; rd_a_addr = 5'd3; rd_b_addr = 5'd4;
    @(posedge clk); #1;
    check("R5 capture A", rd_a_data, model[3]);
    check("R5 capture B", rd_b_data, model[4]);
    @(negedge clk);
    rd_a_addr = 5'd10; rd_b_addr = 5'd11;
    #1;
    check("R5 hold A", rd_a_data, model[3]);
    check("R5 hold B", rd_b_data, model[4]);
    @(posedge clk); #1;
    check("R5 next A", rd_a_data, model[10]);
    check("R5 next B", rd_b_data, model[11]);
  endtask

  task automatic t_sync_collide;
    logic [3:0] old;
    logic [3:0] nw;
    old = model[12]; nw = ~old;
    @(negedge clk);
    rd_mode = 2'b11; rd_a_addr = 5'd12; rd_b_addr = 5'd12;
    wr_en = 1'b1; wr_addr = 5'd12; wr_data = nw;
    @(posedge clk); #1;
    wr_en = 1'b0; model[12] = nw;
    check("R6 old A", rd_a_data, old);
    check("R6 old B", rd_b_data, old);
    @(posedge clk); #1;
    check("R6 new A", rd_a_data, nw);
    check("R6 new B", rd_b_data, nw);
  endtask

  task automatic t_mixed(input logic [1:0] m);
    @(negedge clk);
    rd_mode = m; rd_a_addr = 5'd5; rd_b_addr = 5'd5;
    @(posedge clk); #1;
    @(negedge clk);
    rd_a_addr = 5'd6; rd_b_addr = 5'd6;
    #1;
    check("R7 port A mode", rd_a_data, m[0] ? model[5] : model[6]);
    check("R7 port B mode", rd_b_data, m[1] ? model[5] : model[6]);
  endtask

  task automatic t_reset_keeps;
    @(negedge clk);
    rd_mode = 2'b01; rst = 1'b1; rd_a_addr = 5'd7; rd_b_addr = 5'd7;
    @(posedge clk); #1;
    check("R8 clocked cleared", rd_a_data, 4'h0);
    check("R8 array kept", rd_b_data, model[7]);
    @(negedge clk); rst = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run + 1, n_fail);
    $finish;
  end

  initial begin
    t_reset;
    t_fill;
    t_no_write;
    t_async_no_bypass;
    t_sync_hold;
    t_sync_collide;
    t_mixed(2'b01);
    t_mixed(2'b10);
    t_reset_keeps;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule